// File: doc/BRIEF.md
# AUX Request Frame Packer

This block turns one AUX-channel request into the bytes the line serializer sends, and stores them in a small local transmit buffer. A requester presents a 4-bit command, a 20-bit address, a transfer length, a direction flag and a start strobe. The block then writes the byte sequence into the buffer: header bytes first, then an optional length byte, then the write payload. It also latches the number of bytes the serializer must send. When the last byte is stored it raises a single-cycle go pulse.

Before it touches the buffer, the block acknowledges the serializer's done flag and waits until that flag reads low, so a new frame never overwrites bytes that are still in flight. For writes, the payload arrives one byte per cycle through a valid/request pair. The serializer reads the stored bytes through a read port addressed by index.

Top module: `aux_req_packer`

## Requirements
- R1: Buffer byte 0 holds the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Buffer byte 1 holds address bits 15:8 and byte 2 holds address bits 7:0.
- R3: When the length is nonzero, buffer byte 3 holds the length minus one. When the length is zero, no length byte is written.
- R4: `byte_cnt` equals 3 for a zero length and 4 otherwise, plus the length for writes only. It stays constant while busy.
- R5: For writes, the payload bytes are stored in arrival order starting at the index that follows the header. For reads, no payload is requested or stored.
- R6: After an accepted start, `done_ack` stays high and no buffer byte changes for as long as `ser_done` is high. Loading begins only once `ser_done` is low.
- R7: Every request writes from buffer index 0, whatever length the previous request had.
- R8: A start while busy is ignored. It does not alter the frame in progress and does not queue a second frame.
- R9: `go` is high for exactly one cycle, in the cycle after the last byte is written. `busy` is low in the following cycle.
- R10: A start with a length above 16 raises `err`, leaves `busy` low and writes nothing. The next accepted start clears `err`.
- R11: After reset, `busy`, `err`, `done_ack`, `pay_req` and `go` are low and `byte_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| cmd | input | 4 | Request command code |
| addr | input | 20 | Request address |
| len | input | 5 | Transfer length in bytes, 0 to 16 legal |
| is_wr | input | 1 | 1 for write requests (payload is sent) |
| wvalid | input | 1 | Payload byte valid |
| wdata | input | 8 | Payload byte |
| ser_done | input | 1 | Serializer done flag |
| rd_idx | input | 5 | Buffer read index |
| busy | output | 1 | Request being packed |
| err | output | 1 | Last start rejected for oversize length |
| done_ack | output | 1 | Acknowledge to serializer, held while waiting for ser_done low |
| pay_req | output | 1 | Payload byte wanted this cycle |
| go | output | 1 | One-cycle launch pulse |
| byte_cnt | output | 5 | Number of bytes to transmit |
| rd_data | output | 8 | Buffer byte at rd_idx |

## Verification
The hardest situation to reach is a start that arrives while the serializer still reports done from an earlier frame, combined with a stray start during packing and a payload source that stalls. The stimulus holds `ser_done` high for a random number of cycles after each accepted start, and checks during that time that byte 0 of the previous frame is still readable. It also pulses a conflicting start partway through some frames. Random gaps in `wvalid` stretch the payload phase, and a long write followed by a zero-length read shows that the index restarts at zero.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
    localparam int MAX_LEN = 16;
    localparam int LEN_W   = $clog2(MAX_LEN + 1) + 0;
    localparam int HDR_MAX = 4;
    localparam int DEPTH   = MAX_LEN + HDR_MAX;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_HDR,
        ST_PAY,
        ST_GO
    } pk_state_t;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              wr;
    } pk_req_t;

    function automatic logic [CNT_W-1:0] frame_count(input logic [LEN_W-1:0] n,
                                                     input logic wr);
        logic [CNT_W-1:0] c;
        c = (n == '0) ? CNT_W'(3) : CNT_W'(4);
        if (wr)
            c = c + CNT_W'(n);
        return c;
    endfunction

    function automatic logic [7:0] header_byte(input logic [IDX_W-1:0] i,
                                               input pk_req_t r);
        logic [7:0] b;
        case (i)
            IDX_W'(0): b = {r.cmd, r.addr[19:16]};
            IDX_W'(1): b = r.addr[15:8];
            IDX_W'(2): b = r.addr[7:0];
            default:   b = 8'(r.len) - 8'd1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/aux_req_buf.sv
module aux_req_buf
    import aux_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= 8'h00;
            else if (we && widx == IDX_W'(g))
                mem[g] <= wbyte;
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (int'(ridx) < DEPTH)
            rbyte = mem[ridx];
    end
endmodule

// File: rtl/aux_req_hdr.sv
module aux_req_hdr
    import aux_req_pkg::*;
(
    input  pk_req_t          req,
    input  logic [IDX_W-1:0] idx,
    input  logic             sel_hdr,
    input  logic [7:0]       pay_byte,
    output logic [7:0]       out_byte
);
    always_comb begin
        if (sel_hdr)
            out_byte = header_byte(idx, req);
        else
            out_byte = pay_byte;
    end
endmodule

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
    import aux_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  pk_req_t          in_req,
    input  logic             wvalid,
    input  logic             ser_done,
    output pk_req_t          req,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] cnt,
    output logic             we,
    output logic             sel_hdr,
    output logic             busy,
    output logic             err,
    output logic             done_ack,
    output logic             pay_req,
    output logic             go
);
    pk_state_t        st;
    logic [IDX_W-1:0] hdr_last;
    logic             last_pay;

    assign hdr_last = (req.len == '0) ? IDX_W'(2) : IDX_W'(3);
    assign last_pay = (CNT_W'(idx) == cnt - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            req <= '0;
            idx <= '0;
            cnt <= '0;
            err <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (int'(in_req.len) > MAX_LEN) begin
                            err <= 1'b1;
                        end else begin
                            err <= 1'b0;
                            req <= in_req;
                            cnt <= frame_count(in_req.len, in_req.wr);
                            idx <= '0;
                            st  <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (!ser_done)
                        st <= ST_HDR;
                end
                ST_HDR: begin
                    idx <= idx + IDX_W'(1);
                    if (idx == hdr_last)
                        st <= (req.wr && req.len != '0) ? ST_PAY : ST_GO;
                end
                ST_PAY: begin
                    if (wvalid) begin
                        idx <= idx + IDX_W'(1);
                        if (last_pay)
                            st <= ST_GO;
                    end
                end
                ST_GO: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done_ack = (st == ST_ACK);
    assign pay_req  = (st == ST_PAY);
    assign go       = (st == ST_GO);
    assign sel_hdr  = (st == ST_HDR);
    assign we       = (st == ST_HDR) || ((st == ST_PAY) && wvalid);
endmodule

// File: rtl/aux_req_packer.sv
module aux_req_packer
    import aux_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       cmd,
    input  logic [19:0]      addr,
    input  logic [4:0]       len,
    input  logic             is_wr,
    input  logic             wvalid,
    input  logic [7:0]       wdata,
    input  logic             ser_done,
    input  logic [4:0]       rd_idx,
    output logic             busy,
    output logic             err,
    output logic             done_ack,
    output logic             pay_req,
    output logic             go,
    output logic [4:0]       byte_cnt,
    output logic [7:0]       rd_data
);
    pk_req_t          in_req;
    pk_req_t          cur_req;
    logic [IDX_W-1:0] wr_idx;
    logic             buf_we;
    logic             sel_hdr;
    logic [7:0]       wr_byte;

    assign in_req = '{cmd: cmd, addr: addr, len: len, wr: is_wr};

    aux_req_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_req   (in_req),
        .wvalid   (wvalid),
        .ser_done (ser_done),
        .req      (cur_req),
        .idx      (wr_idx),
        .cnt      (byte_cnt),
        .we       (buf_we),
        .sel_hdr  (sel_hdr),
        .busy     (busy),
        .err      (err),
        .done_ack (done_ack),
        .pay_req  (pay_req),
        .go       (go)
    );

    aux_req_hdr u_hdr (
        .req      (cur_req),
        .idx      (wr_idx),
        .sel_hdr  (sel_hdr),
        .pay_byte (wdata),
        .out_byte (wr_byte)
    );

    aux_req_buf u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .widx  (wr_idx),
        .wbyte (wr_byte),
        .ridx  (rd_idx),
        .rbyte (rd_data)
    );
endmodule

// File: rtl/aux_req_packer_chk.sv
module aux_req_packer_chk
    import aux_req_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             err,
    input logic             done_ack,
    input logic             pay_req,
    input logic             go,
    input logic             ser_done,
    input logic             buf_we,
    input logic [IDX_W-1:0] wr_idx,
    input logic [CNT_W-1:0] byte_cnt
);
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst) go |=> !go); // R9
    AST_GO_THEN_IDLE: assert property (@(posedge clk) disable iff (rst) go |=> !busy); // R9
    AST_GO_AT_COUNT: assert property (@(posedge clk) disable iff (rst) go |-> (CNT_W'(wr_idx) == byte_cnt)); // R4
    AST_CNT_STABLE: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(byte_cnt)); // R4
    AST_ACK_FIRST: assert property (@(posedge clk) disable iff (rst) (busy && !$past(busy)) |-> done_ack); // R6
    AST_NO_WRITE_WHILE_DONE: assert property (@(posedge clk) disable iff (rst) (done_ack && ser_done) |=> !buf_we); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && !go) |=> busy); // R8
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst) err |-> !busy); // R10
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) buf_we |-> (int'(wr_idx) < DEPTH)); // R5
    AST_PAY_NOT_HDR: assert property (@(posedge clk) disable iff (rst) pay_req |-> (int'(wr_idx) >= 4)); // R5
endmodule

bind aux_req_packer aux_req_packer_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .err      (err),
    .done_ack (done_ack),
    .pay_req  (pay_req),
    .go       (go),
    .ser_done (ser_done),
    .buf_we   (buf_we),
    .wr_idx   (wr_idx),
    .byte_cnt (byte_cnt)
);

// File: tb/test_aux_req_packer.sv
module test_aux_req_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic [19:0] addr = '0;
    logic [4:0]  len = '0;
    logic        is_wr = 1'b0;
    logic        wvalid = 1'b0;
    logic [7:0]  wdata = '0;
    logic        ser_done = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic        busy, err, done_ack, pay_req, go;
    logic [4:0]  byte_cnt;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] pay [16];
    logic [7:0] prev_b0 = 8'h00;

    always #4 clk = ~clk;

    aux_req_packer i_aux_req_packer (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .addr(addr), .len(len),
        .is_wr(is_wr), .wvalid(wvalid), .wdata(wdata), .ser_done(ser_done),
        .rd_idx(rd_idx), .busy(busy), .err(err), .done_ack(done_ack),
        .pay_req(pay_req), .go(go), .byte_cnt(byte_cnt), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_cnt(input logic [4:0] n, input logic wr);
        return ((n == 0) ? 5'd3 : 5'd4) + (wr ? n : 5'd0);
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input logic [3:0] c,
                                            input logic [19:0] a, input logic [4:0] n);
        if (i == 0) return {c, a[19:16]};
        if (i == 1) return a[15:8];
        if (i == 2) return a[7:0];
        if (i == 3 && n != 0) return 8'(n) - 8'd1;
        return pay[i - ((n == 0) ? 3 : 4)];
    endfunction

    task automatic do_req(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                          input logic wr, input int hold, input bit inject);
        int k = 0;
        int waited = 0;
        int cyc = 0;
        bit injected = 0;
        bit got_go = 0;
        for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
        @(negedge clk);
        cmd = c; addr = a; len = n; is_wr = wr; start = 1'b1; rd_idx = 5'd0;
        @(negedge clk);
        start = 1'b0;
        while (!got_go && cyc < 400) begin
            cyc++;
            wvalid = 1'b0;
            if (go) begin
                got_go = 1;
                chk("R4 byte count", byte_cnt, exp_cnt(n, wr));
                chk("R9 busy during go", busy, 1'b1);
            end else begin
                if (done_ack) begin
                    if (waited < hold) begin
                        chk("R6 buffer untouched while done high", rd_data, prev_b0);
                        waited++;
                    end else begin
                        ser_done = 1'b0;
                    end
                end
                if (pay_req) begin
                    chk("R5 payload only for writes", {31'd0, wr}, 32'd1);
                    if (($urandom % 4) != 0 && k < 16) begin
                        wvalid = 1'b1;
                        wdata = pay[k];
                        k++;
                    end
                end
                if (inject && !injected && busy && !done_ack) begin
                    start = 1'b1; cmd = ~c; addr = ~a; len = 5'd0; is_wr = 1'b0;
                    injected = 1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
        end
        start = 1'b0;
        wvalid = 1'b0;
        if (!got_go) begin
            checks++; errors++;
            $display("FAIL R9: actual no go expected go within 400 cycles");
        end
        chk("R6 ack phase observed", {31'd0, (waited == hold)}, 32'd1);
        @(negedge clk);
        chk("R9 go one cycle", go, 1'b0);
        chk("R9 idle after go", busy, 1'b0);
        ser_done = 1'b1;
        for (int i = 0; i < int'(exp_cnt(n, wr)); i++) begin
            rd_idx = 5'(i);
            #1;
            if (i == 0) chk("R1 byte0", rd_data, exp_byte(i, c, a, n));
            else if (i < 3) chk("R2 address byte", rd_data, exp_byte(i, c, a, n));
            else if (i == 3 && n != 0) chk("R3 length byte", rd_data, exp_byte(i, c, a, n));
            else chk("R5 payload byte", rd_data, exp_byte(i, c, a, n));
        end
        rd_idx = 5'd0;
        #1;
        prev_b0 = rd_data;
        if (inject) begin
            @(negedge clk);
            chk("R8 stray start not queued", busy, 1'b0);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 busy", busy, 1'b0);
        chk("R11 err", err, 1'b0);
        chk("R11 ack", done_ack, 1'b0);
        chk("R11 pay_req", pay_req, 1'b0);
        chk("R11 go", go, 1'b0);
        chk("R11 count", byte_cnt, 5'd0);

        do_req(4'h9, 20'hABCDE, 5'd0, 1'b0, 0, 0);
        do_req(4'h8, 20'h12345, 5'd16, 1'b1, 3, 0);
        do_req(4'h1, 20'h00F0F, 5'd0, 1'b0, 2, 0);   // R7 short frame after long one
        do_req(4'h0, 20'hFFFFF, 5'd1, 1'b1, 1, 0);
        do_req(4'h5, 20'h54321, 5'd16, 1'b0, 0, 1);  // R8 stray start mid-frame
        do_req(4'h4, 20'h0A0A0, 5'd5, 1'b1, 4, 1);

        @(negedge clk);
        len = 5'd17; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 err raised", err, 1'b1);
        chk("R10 not busy", busy, 1'b0);
        rd_idx = 5'd0; #1;
        chk("R10 buffer untouched", rd_data, prev_b0);
        @(negedge clk);
        len = 5'd31; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 err max len", err, 1'b1);
        chk("R10 no ack", done_ack, 1'b0);
        do_req(4'h2, 20'h13579, 5'd2, 1'b1, 0, 0);
        chk("R10 err cleared", err, 1'b0);

        for (int t = 0; t < 40; t++) begin
            do_req(4'($urandom), 20'($urandom), 5'($urandom % 17), 1'($urandom),
                   int'($urandom % 4), bit'(($urandom % 5) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule